// File: doc/BRIEF.md
# Copier Program/Character Bank Selector

This block decides where a cartridge copier fetches program code, character data and nametable layout from. It works in three ways. In the first, the copier runs from a 32 KB window of its own internal ROM. In the second, control passes to an inserted cartridge, whose mapper outputs are passed through unchanged. In the third, the block emulates a simple mapper: one 32 KB switchable bank plus single-screen mirroring. In that mode, CPU writes to the upper half of the address space are captured locally instead of reaching the cartridge mapper.

CPU writes to the $8000-$FFFF window arrive on a valid/ready stream. When the emulated mode is off, each write passes straight through to a forwarding stream toward the external mapper. Valid, address and data move through in the same cycle, and ready is returned from the mapper side. A source holds `bus_valid`, `bus_addr` and `bus_data` steady until it sees `bus_ready` high at a rising edge. The transfer happens on the edge where both are high. When the emulated mode is on, the block accepts every write at once. Mode bits, the cartridge-absent flag and the software bank write port are plain level or strobe inputs. All bank, character and mirroring outputs are registered.

Top module: `copier_bank_mux`

## Requirements
- R1: With `cart_en` low, `prg_bank` equals the bank register's low four bits XOR 0x8, zero-extended, and `prg_from_cart` is low.
- R2: With `cart_en` high, `prg_bank` equals `ext_prg_bank` and `prg_from_cart` is high.
- R3: With `simple_mode` high, a write handshake loads the bank register with `bus_data[4:0]`, for any `cart_en`. `fwd_valid` stays low and `bus_ready` stays high.
- R4: With `simple_mode` low, a bus write is presented on the forwarding port with the same address and data. `fwd_irq_grp` equals `bus_addr[14]` (1 for $C000-$FFFF, 0 for $8000-$BFFF). The bank register is unchanged.
- R5: With `simple_mode` low, `bus_ready` follows `fwd_ready` in the same cycle. While `fwd_ready` is low, the write is held off.
- R6: With `simple_mode` high, `mirror` is single-screen. The code is 2 (page 0) when bank register bit 4 is 0, and 3 (page 1) when it is 1.
- R7: With `simple_mode` low, `mirror` follows `ext_mirror_bit` inverted. An input of 0 gives code 1 (vertical), and an input of 1 gives code 0 (horizontal).
- R8: `chr_internal` is high exactly when `simple_mode` and `cart_absent` are both high. Otherwise the cartridge's character banks are used.
- R9: Reset loads the bank register with 0x08, so internal bank 0 is selected. During reset, all outputs read 0.
- R10: The outputs are registered. A bank register update taken at edge k appears on the outputs at edge k+1. A mode or external input change appears at the next edge.
- R11: When `bank_we` and an emulated-mode bus write arrive in the same cycle, the software value `bank_wdata` is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cart_en | input | 1 | Pass program banking to the cartridge mapper |
| simple_mode | input | 1 | Emulate the 32 KB single-screen mapper |
| cart_absent | input | 1 | Status: no cartridge in the slot |
| bank_we | input | 1 | Software write strobe for the bank register |
| bank_wdata | input | 5 | Software bank register value |
| bus_valid | input | 1 | CPU write in $8000-$FFFF is valid |
| bus_ready | output | 1 | CPU write is accepted |
| bus_addr | input | 15 | Write address offset from $8000 |
| bus_data | input | 8 | Write data |
| fwd_valid | output | 1 | Forwarded write valid toward the mapper |
| fwd_ready | input | 1 | Mapper accepts the forwarded write |
| fwd_irq_grp | output | 1 | 1: IRQ register group, 0: command group |
| fwd_addr | output | 15 | Forwarded address |
| fwd_data | output | 8 | Forwarded data |
| ext_prg_bank | input | 8 | Program bank from the cartridge mapper |
| ext_mirror_bit | input | 1 | Mirroring bit written to the cartridge mapper |
| prg_bank | output | 8 | Selected program bank |
| prg_from_cart | output | 1 | Program fetches go to the cartridge |
| chr_internal | output | 1 | Character fetches use the internal 8 KB RAM |
| mirror | output | 2 | 0 horizontal, 1 vertical, 2 page 0, 3 page 1 |

## Verification
The hardest case to reach is a write that lands in emulated mode while the cartridge is enabled. Here the bank register changes but is hidden, because `prg_bank` shows the cartridge's bank. The stimulus makes that write with `cart_en` high, then clears `cart_en` and reads the stored value back through the internal-bank path. Stalled forwarding and a bus write colliding with a software write are each set up as their own vectors, with `fwd_ready` held low or `bank_we` pulsed in the same cycle as `bus_valid`.

// File: rtl/copier_bank_pkg.sv
package copier_bank_pkg;
  typedef enum logic [1:0] {
    MIR_HORZ  = 2'd0,
    MIR_VERT  = 2'd1,
    MIR_PAGE0 = 2'd2,
    MIR_PAGE1 = 2'd3
  } mirror_e;
endpackage

// File: rtl/copier_bank_reg.sv
module copier_bank_reg #(
  parameter int BANK_W = 5,
  parameter logic [BANK_W-1:0] RESET_VAL = 5'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [BANK_W-1:0] sw_data,
  input  logic              bus_we,
  input  logic [BANK_W-1:0] bus_data,
  output logic [BANK_W-1:0] bank_q
);
  // software store takes precedence over a same-cycle bus capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_q <= RESET_VAL;
    else if (sw_we)  bank_q <= sw_data;
    else if (bus_we) bank_q <= bus_data;
  end
endmodule

// File: rtl/copier_bus_router.sv
module copier_bus_router #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              simple_mode,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic              fwd_irq_grp,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              capture
);
  always_comb begin
    fwd_valid   = bus_valid & ~simple_mode;
    bus_ready   = simple_mode | fwd_ready;
    capture     = bus_valid & simple_mode;
    fwd_irq_grp = bus_addr[ADDR_W-1];
    fwd_addr    = bus_addr;
    fwd_data    = bus_data;
  end
endmodule

// File: rtl/copier_out_stage.sv
module copier_out_stage
  import copier_bank_pkg::*;
#(
  parameter int BANK_W     = 5,
  parameter int INT_BANK_W = 4,
  parameter int PRG_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cart_en,
  input  logic              simple_mode,
  input  logic              cart_absent,
  input  logic [BANK_W-1:0] bank_q,
  input  logic [PRG_W-1:0]  ext_prg_bank,
  input  logic              ext_mirror_bit,
  output logic [PRG_W-1:0]  prg_bank,
  output logic              prg_from_cart,
  output logic              chr_internal,
  output logic [1:0]        mirror
);
  localparam logic [INT_BANK_W-1:0] BANK_FLIP = INT_BANK_W'(1) << (INT_BANK_W-1);
  localparam int PAGE_BIT = BANK_W - 1;

  logic [PRG_W-1:0] int_bank;
  logic [PRG_W-1:0] prg_d;
  mirror_e          mir_d;

  always_comb begin
    int_bank = '0;
    int_bank[INT_BANK_W-1:0] = bank_q[INT_BANK_W-1:0] ^ BANK_FLIP;
    prg_d = cart_en ? ext_prg_bank : int_bank;
    if (simple_mode) mir_d = bank_q[PAGE_BIT] ? MIR_PAGE1 : MIR_PAGE0;
    else             mir_d = ext_mirror_bit ? MIR_HORZ : MIR_VERT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_bank      <= '0;
      prg_from_cart <= 1'b0;
      chr_internal  <= 1'b0;
      mirror        <= MIR_HORZ;
    end else begin
      prg_bank      <= prg_d;
      prg_from_cart <= cart_en;
      chr_internal  <= simple_mode & cart_absent;
      mirror        <= mir_d;
    end
  end
endmodule

// File: rtl/copier_bank_mux.sv
module copier_bank_mux #(
  parameter int BANK_W     = 5,
  parameter int INT_BANK_W = 4,
  parameter int PRG_W      = 8,
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cart_en,
  input  logic              simple_mode,
  input  logic              cart_absent,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic              fwd_irq_grp,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  input  logic [PRG_W-1:0]  ext_prg_bank,
  input  logic              ext_mirror_bit,
  output logic [PRG_W-1:0]  prg_bank,
  output logic              prg_from_cart,
  output logic              chr_internal,
  output logic [1:0]        mirror
);
  localparam logic [BANK_W-1:0] BANK_RST = BANK_W'(1) << (INT_BANK_W-1);

  logic              capture;
  logic [BANK_W-1:0] bank_q;

  copier_bus_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_router (
    .simple_mode (simple_mode),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .fwd_valid   (fwd_valid),
    .fwd_ready   (fwd_ready),
    .fwd_irq_grp (fwd_irq_grp),
    .fwd_addr    (fwd_addr),
    .fwd_data    (fwd_data),
    .capture     (capture)
  );

  copier_bank_reg #(.BANK_W(BANK_W), .RESET_VAL(BANK_RST)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (bank_we),
    .sw_data  (bank_wdata),
    .bus_we   (capture),
    .bus_data (bus_data[BANK_W-1:0]),
    .bank_q   (bank_q)
  );

  copier_out_stage #(.BANK_W(BANK_W), .INT_BANK_W(INT_BANK_W), .PRG_W(PRG_W)) u_out (
    .clk            (clk),
    .rst_n          (rst_n),
    .cart_en        (cart_en),
    .simple_mode    (simple_mode),
    .cart_absent    (cart_absent),
    .bank_q         (bank_q),
    .ext_prg_bank   (ext_prg_bank),
    .ext_mirror_bit (ext_mirror_bit),
    .prg_bank       (prg_bank),
    .prg_from_cart  (prg_from_cart),
    .chr_internal   (chr_internal),
    .mirror         (mirror)
  );
endmodule

// File: rtl/copier_bank_mux_chk.sv
module copier_bank_mux_chk #(
  parameter int BANK_W     = 5,
  parameter int INT_BANK_W = 4,
  parameter int PRG_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cart_en,
  input logic              simple_mode,
  input logic              cart_absent,
  input logic              bank_we,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [BANK_W-1:0] bus_low,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [BANK_W-1:0] bank_q,
  input logic [PRG_W-1:0]  prg_bank,
  input logic              prg_from_cart,
  input logic              chr_internal
);
  localparam logic [INT_BANK_W-1:0] FLIP = INT_BANK_W'(1) << (INT_BANK_W-1);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r3_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    simple_mode |-> !fwd_valid);

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (simple_mode && bus_valid && !bank_we) |=> bank_q == $past(bus_low));

  a_r4_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!simple_mode && !bank_we) |=> $stable(bank_q));

  a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |-> !bus_ready);

  a_r8_chr_src: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> chr_internal == $past(simple_mode && cart_absent));

  a_r1_int_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !prg_from_cart) |->
      prg_bank[INT_BANK_W-1:0] == ($past(bank_q[INT_BANK_W-1:0]) ^ FLIP));
endmodule

bind copier_bank_mux copier_bank_mux_chk #(
  .BANK_W(BANK_W), .INT_BANK_W(INT_BANK_W), .PRG_W(PRG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cart_en       (cart_en),
  .simple_mode   (simple_mode),
  .cart_absent   (cart_absent),
  .bank_we       (bank_we),
  .bus_valid     (bus_valid),
  .bus_ready     (bus_ready),
  .bus_low       (bus_data[BANK_W-1:0]),
  .fwd_valid     (fwd_valid),
  .fwd_ready     (fwd_ready),
  .bank_q        (bank_q),
  .prg_bank      (prg_bank),
  .prg_from_cart (prg_from_cart),
  .chr_internal  (chr_internal)
);

// File: tb/test_copier_bank_mux.sv
module test_copier_bank_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cart_en = 0, simple_mode = 0, cart_absent = 0, bank_we = 0;
  logic [4:0] bank_wdata = '0;
  logic bus_valid = 0, fwd_ready = 1, ext_mirror_bit = 0;
  logic [14:0] bus_addr = '0;
  logic [7:0] bus_data = '0, ext_prg_bank = '0;
  logic bus_ready, fwd_valid, fwd_irq_grp, prg_from_cart, chr_internal;
  logic [14:0] fwd_addr;
  logic [7:0] fwd_data, prg_bank;
  logic [1:0] mirror;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  copier_bank_mux i_copier_bank_mux (
    .clk(clk), .rst_n(rst_n), .cart_en(cart_en), .simple_mode(simple_mode),
    .cart_absent(cart_absent), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_data(bus_data), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_irq_grp(fwd_irq_grp), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .ext_prg_bank(ext_prg_bank), .ext_mirror_bit(ext_mirror_bit),
    .prg_bank(prg_bank), .prg_from_cart(prg_from_cart),
    .chr_internal(chr_internal), .mirror(mirror)
  );

  typedef struct packed {
    logic       cart, simple, absent, we;
    logic [4:0] wdata;
    logic       wr, a14;
    logic [7:0] data;
    logic       fready;
    logic [7:0] eprg;
    logic       emir;
    logic [7:0] x_prg;
    logic       x_cart, x_chr;
    logic [1:0] x_mir;
    logic       x_fv, x_rdy;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,5'h00,1'b0,1'b0,8'h00,1'b1,8'h33,1'b0, 8'h00,1'b0,1'b0,2'd1,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,5'h00,1'b1,1'b1,8'h15,1'b0,8'h33,1'b0, 8'h0D,1'b0,1'b0,2'd3,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,5'h00,1'b1,1'b0,8'hE3,1'b0,8'h33,1'b0, 8'h0B,1'b0,1'b1,2'd2,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,5'h00,1'b1,1'b1,8'h1F,1'b1,8'h33,1'b1, 8'h0B,1'b0,1'b0,2'd0,1'b1,1'b1},
    '{1'b0,1'b0,1'b1,1'b0,5'h00,1'b1,1'b0,8'h1C,1'b0,8'h33,1'b0, 8'h0B,1'b0,1'b0,2'd1,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,5'h00,1'b0,1'b0,8'h00,1'b0,8'h5A,1'b1, 8'h5A,1'b1,1'b0,2'd0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,5'h00,1'b0,1'b0,8'h00,1'b0,8'h5A,1'b1, 8'h5A,1'b1,1'b1,2'd2,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,5'h17,1'b0,1'b0,8'h00,1'b1,8'h5A,1'b0, 8'h0F,1'b0,1'b0,2'd1,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b1,5'h02,1'b1,1'b0,8'h11,1'b0,8'h5A,1'b0, 8'h0A,1'b0,1'b0,2'd2,1'b0,1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9 reset state
    #1;
    check("R9 prg in reset", prg_bank, 0);
    check("R9 mirror in reset", mirror, 0);
    check("R9 chr in reset", chr_internal, 0);
    settle(2);
    rst_n = 1'b1;
    settle(2);
    check("R9 bank 0x08 gives bank 0", prg_bank, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cart_en = VECS[i].cart; simple_mode = VECS[i].simple;
      cart_absent = VECS[i].absent; fwd_ready = VECS[i].fready;
      ext_prg_bank = VECS[i].eprg; ext_mirror_bit = VECS[i].emir;
      bank_we = VECS[i].we; bank_wdata = VECS[i].wdata;
      bus_valid = VECS[i].wr; bus_addr = {VECS[i].a14, 14'h0123};
      bus_data = VECS[i].data;
      #1;
      check("R3/R4 fwd_valid", fwd_valid, VECS[i].x_fv);
      check("R5 bus_ready", bus_ready, VECS[i].x_rdy);
      if (VECS[i].x_fv) begin
        check("R4 irq group", fwd_irq_grp, VECS[i].a14);
        check("R4 fwd data", fwd_data, VECS[i].data);
        check("R4 fwd addr", fwd_addr, {VECS[i].a14, 14'h0123});
      end
      @(negedge clk);
      bus_valid = 1'b0; bank_we = 1'b0;
      settle(1);
      check("R1/R2/R11 prg_bank", prg_bank, VECS[i].x_prg);
      check("R1/R2 prg_from_cart", prg_from_cart, VECS[i].x_cart);
      check("R8 chr_internal", chr_internal, VECS[i].x_chr);
      check("R6/R7 mirror", mirror, VECS[i].x_mir);
    end

    // R10 latency: bank register at edge k, output at edge k+1
    cart_en = 0; simple_mode = 0;
    settle(2);
    bank_we = 1'b1; bank_wdata = 5'h0C;
    @(negedge clk);
    bank_we = 1'b0;
    check("R10 output not yet updated", prg_bank, 8'h0A);
    @(negedge clk);
    check("R10 output updated", prg_bank, 8'h04);

    // R3 capture while cartridge enabled, read back through internal path
    cart_en = 1; simple_mode = 1; ext_prg_bank = 8'h77;
    bus_valid = 1'b1; bus_data = 8'h09; bus_addr = 15'h4000;
    #1;
    check("R3 no forward with cart enabled", fwd_valid, 0);
    @(negedge clk);
    bus_valid = 1'b0;
    settle(1);
    check("R2 cart bank hides capture", prg_bank, 8'h77);
    cart_en = 0;
    settle(2);
    check("R3 captured bank visible", prg_bank, 8'h01);
    check("R6 page 0 after capture", mirror, 2);

    // R9 reset mid-run restores bank 0x08
    rst_n = 1'b0;
    #1;
    check("R9 prg cleared", prg_bank, 0);
    settle(1);
    rst_n = 1'b1;
    simple_mode = 0;
    settle(2);
    check("R9 internal bank 0 after reset", prg_bank, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule